// File: doc/BRIEF.md
# Byte-Lane Saturating Adder

This block is a 32-bit combinational add/subtract unit with two personalities. In scalar mode it is an ordinary full-width adder: the carry ripples through all 32 bits and the result wraps modulo 2^32. In vector mode the word is cut into four independent 8-bit lanes. Each lane holds an unsigned pixel intensity, and each lane is added or subtracted in parallel with the same lane of the other operand.

In vector mode a lane result that leaves the 0..255 range is clamped to the nearest end, so a bright pixel stays bright instead of turning dark. The lanes share one segmented adder. In vector mode the carry links between segments are cut and each segment gets its own carry-in. The carry-out of each segment then decides whether that lane clamps.

The result depends only on the present inputs. There is no clock, state, flag or exception.

Top module: `vsat_adder`

## Requirements
- R1: Mode 2'b00 (scalar add) gives res_o = (a_i + b_i) mod 2^32, with the carry passing across every byte boundary.
- R2: Mode 2'b01 (scalar subtract) gives res_o = (a_i - b_i) mod 2^32, with the borrow passing across every byte boundary (0x00000100 - 1 = 0x000000FF).
- R3: Mode 2'b10 (vector add): for each lane whose unsigned sum is at most 255, that lane of res_o equals the sum of the two operand lanes.
- R4: Mode 2'b10: for each lane whose unsigned sum exceeds 255, that lane of res_o is 255 (243 + 124 gives 255).
- R5: Mode 2'b11 (vector subtract): for each lane where the a_i lane is at least the b_i lane, that lane of res_o is their difference.
- R6: Mode 2'b11: for each lane where the a_i lane is less than the b_i lane, that lane of res_o is 0.
- R7: Lanes are bits [7:0], [15:8], [23:16] and [31:24]. In vector modes, lane i of res_o depends only on lane i of a_i and b_i, and no carry or borrow moves between lanes.
- R8: Mode bit 1 selects vector (1) or scalar (0) operation. Mode bit 0 selects subtract (1) or add (0).
- R9: The unit is purely combinational: res_o follows a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand (minuend for subtract) |
| b_i | input | 32 | Second operand (subtrahend for subtract) |
| mode_i | input | 2 | Operation select: bit 1 vector, bit 0 subtract |
| res_o | output | 32 | Packed result |

## Verification
Because the block holds no state, a fault appears at res_o as soon as the inputs that expose it are applied. A broken segment link shows up in scalar mode as a wrong upper byte whenever a low byte carries or borrows. A link that fails to cut shows up in vector mode as a neighbour lane off by one. A wrong clamp polarity shows up as a dark value where 255 is expected, or as a wrapped difference where 0 is expected. The lane sweeps cover every 8-bit operand pair in every lane position, so each of these faults is exposed.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  // bit 1 = vector, bit 0 = subtract
  typedef enum logic [1:0] {
    MODE_S_ADD = 2'b00,
    MODE_S_SUB = 2'b01,
    MODE_V_ADD = 2'b10,
    MODE_V_SUB = 2'b11
  } mode_e;

  typedef struct packed {
    logic vec;
    logic sub;
  } op_ctl_t;
endpackage

// File: rtl/vsat_mode_dec.sv
module vsat_mode_dec
  import vsat_pkg::*;
(
  input  logic [1:0] mode_i,
  output op_ctl_t    ctl_o
);
  mode_e mode;
  assign mode = mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_S_ADD: ctl_o = '{vec: 1'b0, sub: 1'b0};
      MODE_S_SUB: ctl_o = '{vec: 1'b0, sub: 1'b1};
      MODE_V_ADD: ctl_o = '{vec: 1'b1, sub: 1'b0};
      MODE_V_SUB: ctl_o = '{vec: 1'b1, sub: 1'b1};
      default:    ctl_o = '{vec: 1'b0, sub: 1'b0};
    endcase
  end
endmodule

// File: rtl/vsat_operand_prep.sv
module vsat_operand_prep #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] b_eff_o
);
  // subtract as a + ~b + 1; the +1 enters as segment carry-in
  assign b_eff_o = sub_i ? ~b_i : b_i;
endmodule

// File: rtl/vsat_seg_adder.sv
module vsat_seg_adder #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              split_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [LANES-1:0]  co_o
);
  logic [LANES-1:0] seg_ci;

  for (genvar k = 0; k < LANES; k++) begin : g_seg
    logic [LANE_W:0] t;
    if (k == 0) begin : g_base
      assign seg_ci[k] = cin_i;
    end else begin : g_link
      // cut the chain at lane boundaries in vector mode
      assign seg_ci[k] = split_i ? cin_i : co_o[k-1];
    end
    assign t = {1'b0, a_i[k*LANE_W +: LANE_W]}
             + {1'b0, b_i[k*LANE_W +: LANE_W]}
             + {{LANE_W{1'b0}}, seg_ci[k]};
    assign sum_o[k*LANE_W +: LANE_W] = t[LANE_W-1:0];
    assign co_o[k] = t[LANE_W];
  end
endmodule

// File: rtl/vsat_lane_clamp.sv
module vsat_lane_clamp #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] sum_i,
  input  logic [LANES-1:0]  co_i,
  input  logic              vec_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic sat_hi, sat_lo;
    // add: carry-out means overflow; sub: no carry-out means borrow
    assign sat_hi = vec_i & ~sub_i &  co_i[k];
    assign sat_lo = vec_i &  sub_i & ~co_i[k];
    always_comb begin
      if (sat_hi)      res_o[k*LANE_W +: LANE_W] = '1;
      else if (sat_lo) res_o[k*LANE_W +: LANE_W] = '0;
      else             res_o[k*LANE_W +: LANE_W] = sum_i[k*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/vsat_adder.sv
module vsat_adder
  import vsat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] res_o
);
  op_ctl_t           ctl;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic [LANES-1:0]  lane_co;

  vsat_mode_dec u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  vsat_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .b_i     (b_i),
    .sub_i   (ctl.sub),
    .b_eff_o (b_eff)
  );

  vsat_seg_adder #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_add (
    .a_i     (a_i),
    .b_i     (b_eff),
    .cin_i   (ctl.sub),
    .split_i (ctl.vec),
    .sum_o   (sum),
    .co_o    (lane_co)
  );

  vsat_lane_clamp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_clamp (
    .sum_i (sum),
    .co_i  (lane_co),
    .vec_i (ctl.vec),
    .sub_i (ctl.sub),
    .res_o (res_o)
  );
endmodule

// File: rtl/vsat_adder_chk.sv
module vsat_adder_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] res_o,
  input logic [LANES-1:0]  lane_co
);
  always_comb begin
    if (mode_i == 2'b00)
      p_scalar_add_r1: assert (res_o == DATA_W'(a_i + b_i));
    if (mode_i == 2'b01)
      p_scalar_sub_r2: assert (res_o == DATA_W'(a_i - b_i));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, r_l;
    assign a_l = a_i[k*LANE_W +: LANE_W];
    assign b_l = b_i[k*LANE_W +: LANE_W];
    assign r_l = res_o[k*LANE_W +: LANE_W];
    always_comb begin
      if (mode_i == 2'b10) begin
        p_add_floor_r3: assert (r_l >= a_l && r_l >= b_l);
        p_sat_hi_r4:    assert (!lane_co[k] || r_l == '1);
      end
      if (mode_i == 2'b11) begin
        p_sub_ceil_r5: assert (r_l <= a_l);
        p_sat_lo_r6:   assert (lane_co[k] || r_l == '0);
      end
    end
  end
endmodule

bind vsat_adder vsat_adder_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .mode_i  (mode_i),
  .res_o   (res_o),
  .lane_co (lane_co)
);

// File: tb/sim_vsat_adder.sv
`timescale 1ns/1ps
module sim_vsat_adder;
  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [1:0]  mode;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vsat_adder u0 (
    .a_i    (a),
    .b_i    (b),
    .mode_i (mode),
    .res_o  (res)
  );

  function automatic logic [7:0] lane_ref(logic [7:0] x, logic [7:0] y, logic sub);
    int r;
    r = sub ? int'(x) - int'(y) : int'(x) + int'(y);
    if (r > 255) r = 255;
    if (r < 0)   r = 0;
    return 8'(r);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] m, logic [31:0] x, logic [31:0] y);
    mode = m; a = x; b = y;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    apply(2'b00, 32'h0, 32'h0);
    @(negedge clk);
    chk("R1 idle", res, 32'h0);

    // R2/R1 carry and borrow across byte boundaries
    apply(2'b00, 32'h000000FF, 32'h00000001); chk("R1 carry", res, 32'h00000100);
    apply(2'b00, 32'hFFFFFFFF, 32'h00000001); chk("R1 wrap", res, 32'h00000000);
    apply(2'b01, 32'h00000100, 32'h00000001); chk("R2 borrow", res, 32'h000000FF);
    apply(2'b01, 32'h00000000, 32'h00000001); chk("R2 wrap", res, 32'hFFFFFFFF);

    // R7 lane isolation
    apply(2'b10, 32'h000000FF, 32'h00000001); chk("R7 add iso", res, 32'h000000FF);
    apply(2'b11, 32'h00000100, 32'h00000001); chk("R7 sub iso", res, 32'h00000100);
    apply(2'b10, 32'h7F80FF01, 32'h01800100); chk("R7 mixed", res, 32'h80FFFF01);

    // R4 named example and R6 equal operands
    apply(2'b10, 32'h000000F3, 32'h0000007C); chk("R4 243+124", res, 32'h000000FF);
    apply(2'b11, 32'h5A5A5A5A, 32'h5A5A5A5A); chk("R6 equal", res, 32'h00000000);

    // R8 same operands under each mode
    apply(2'b00, 32'h10F0_0120, 32'h2020_0230); chk("R8 s_add", res, 32'h31100350);
    apply(2'b01, 32'h10F0_0120, 32'h2020_0230); chk("R8 s_sub", res, 32'hF0CFFEF0);
    apply(2'b10, 32'h10F0_0120, 32'h2020_0230); chk("R8 v_add", res, 32'h30FF0350);
    apply(2'b11, 32'h10F0_0120, 32'h2020_0230); chk("R8 v_sub", res, 32'h00D00000);

    // R9 input change reflected without a clock edge
    @(posedge clk); #2;
    a = 32'h00000010; b = 32'h00000020; mode = 2'b11;
    #1 chk("R9 comb", res, 32'h00000000);

    // scalar sweep R1/R2
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] x, y;
      x = 32'(i) * 32'h9E3779B1;
      y = (32'(i) * 32'h7F4A7C15) ^ 32'h00FF00FF;
      apply(2'b00, x, y); chk("R1 sweep", res, x + y);
      apply(2'b01, x, y); chk("R2 sweep", res, x - y);
    end

    // exhaustive lane sweep R3..R6, every pair in every lane position
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int s = 0; s < 2; s++) begin
          logic [7:0]  xv, yv;
          logic [31:0] va, vb;
          xv = 8'(x); yv = 8'(y);
          va = {~xv, xv ^ 8'h5A, yv, xv};
          vb = {yv, yv, xv, yv};
          apply({1'b1, 1'(s)}, va, vb);
          for (int k = 0; k < 4; k++) begin
            logic [7:0] ea, eb, er;
            int         raw;
            ea  = va[k*8 +: 8];
            eb  = vb[k*8 +: 8];
            er  = lane_ref(ea, eb, 1'(s));
            raw = s ? int'(ea) - int'(eb) : int'(ea) + int'(eb);
            if (s == 0) chk(raw > 255 ? "R4 lane" : "R3 lane", {24'h0, res[k*8 +: 8]}, {24'h0, er});
            else        chk(raw < 0   ? "R6 lane" : "R5 lane", {24'h0, res[k*8 +: 8]}, {24'h0, er});
          end
        end
      end
    end

    finish_run();
  end
endmodule